// File: doc/BRIEF.md
# Serial EEPROM Boot Record Loader

This block loads a program image from a serial EEPROM once reset is released. It acts as an SPI master and works out whether the attached device needs a two-byte or a three-byte read address. It then walks a chain of typed records and copies each payload byte into one of three target memories through a simple write port. The walk ends at an execute record. The block then reports that record's address as the program entry point and goes idle.

A strap input decides whether the loader runs at all. If the strap is low after reset, or if no valid signature is found, the block raises `skipped` at once and leaves the bus alone. Other boot sources can then take over. Each record has the same header: a type byte, a length (low byte first), a target address (low byte first), and then `length` payload bytes.

The controller has these states:

- ST_STRAP samples the strap.
- ST_SIG_CMD sends the read command and two zero address bytes.
- ST_SIG_RD collects four signature bytes.
- ST_SIG_CHK releases chip select and selects the address mode.
- ST_REC_CMD reopens the device at byte 4.
- ST_HDR collects the five header bytes.
- ST_DATA streams the payload.
- ST_EXEC and ST_SKIP are terminal.

The transitions are:

- ST_STRAP goes to ST_SIG_CMD when the strap is high, or to ST_SKIP when it is low.
- ST_SIG_CMD goes to ST_SIG_RD after its third byte.
- ST_SIG_RD goes to ST_SIG_CHK after its fourth byte.
- ST_SIG_CHK goes to ST_REC_CMD on a match, or to ST_SKIP otherwise.
- ST_REC_CMD goes to ST_HDR after its last address byte.
- ST_HDR goes to ST_EXEC on an execute type.
- ST_HDR goes back to ST_HDR on a zero length.
- ST_HDR goes to ST_DATA otherwise.
- ST_DATA goes to ST_HDR after the last payload byte.

Top module: `spi_boot_loader`

## Requirements
- R1: When `boot_en` is low at the first clock after reset, `skipped` rises within 3 cycles, `cs_n` is never driven low and no write strobe occurs.
- R2: The SPI port uses mode 0. `sclk` stays low whenever `cs_n` is high, `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising `sclk` edge. Each read begins with command byte 0x03 and then the address MSB first. The first read uses address 0x0000 and fetches four bytes.
- R3: If the four signature bytes are 0x56 0x4C 0x53 0x49, the loader uses two address bytes for the record read.
- R4: Otherwise, if signature bytes 1 to 3 are 0x56 0x4C 0x53, the loader uses three address bytes for the record read.
- R5: If neither pattern matches, the loader ends with `skipped` high and issues no writes.
- R6: Record parsing reads sequentially from byte address 4 under one continuous `cs_n` low period. Each record is laid out as type, length low, length high, target low, target high, then the payload.
- R7: Types 0, 1 and 2 give one single-cycle `wr_en` pulse per payload byte, with `wr_mem` equal to the type. `wr_addr` is the target plus the byte offset, modulo 2^16.
- R8: A record with any type above 3 has its payload consumed without any write strobe.
- R9: A record with a length of zero produces no writes, and parsing continues at the next record.
- R10: On a type-3 record, `done` rises, `exec_addr` shows the record's target field and `cs_n` returns high.
- R11: During reset `done`, `skipped` and `wr_en` are low and `cs_n` is high. `done` and `skipped` never both hold, and each stays high until the next reset with no further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_en | input | 1 | Strap enabling the serial boot attempt |
| miso | input | 1 | Serial data from the EEPROM |
| sclk | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | Active-low EEPROM select |
| mosi | output | 1 | Serial data to the EEPROM |
| wr_en | output | 1 | Single-cycle write strobe |
| wr_mem | output | 2 | Target memory: 0 instruction, 1 X data, 2 Y data |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data byte |
| done | output | 1 | Execute record reached |
| skipped | output | 1 | Serial boot not performed |
| exec_addr | output | 16 | Entry address from the execute record |

## Verification
A wrong address mode shows up on the next read: the record stream starts one byte off, so the first write carries the wrong memory select or data, or the walk runs into the skip outcome. A header byte that lands in the wrong field corrupts the length or target of that record. That error is visible at the first write of the record, or as a wrong write count when `done` rises. A stuck or wrong terminal state shows as overlapping or dropped `done`/`skipped`, or as strobes after the end, which the bound checks catch on the cycle it happens.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
    localparam int          TGT_W     = 16;
    localparam int          MEM_SEL_W = 2;
    localparam logic [7:0]  CMD_READ  = 8'h03;
    localparam logic [7:0]  REC_BASE  = 8'h04;
    localparam logic [7:0]  TYPE_EXEC = 8'd3;
    localparam logic [7:0]  TYPE_LAST_MEM = 8'd2;
    localparam logic [31:0] SIG_WORD  = 32'h564C_5349;

    typedef enum logic [3:0] {
        ST_STRAP, ST_SIG_CMD, ST_SIG_RD, ST_SIG_CHK,
        ST_REC_CMD, ST_HDR, ST_DATA, ST_EXEC, ST_SKIP
    } ldr_state_t;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       xdone,
    output logic [7:0] rx_byte
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    tx_sh;

    assign mosi = tx_sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0; sclk <= 1'b0; cnt <= '0; bitn <= '0;
            tx_sh <= '0; rx_byte <= '0; xdone <= 1'b0;
        end else begin
            xdone <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                tx_sh <= tx_byte;
                cnt   <= '0;
                bitn  <= '0;
            end else if (busy) begin
                if (cnt == CNT_TOP) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk  <= 1'b0;
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        if (bitn == 3'd7) begin
                            busy  <= 1'b0;
                            xdone <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/boot_sig_match.sv
module boot_sig_match
    import spi_boot_pkg::*;
(
    input  logic [31:0] sig,
    output logic        is16,
    output logic        is24
);
    assign is16 = (sig == SIG_WORD);
    assign is24 = (sig[23:0] == SIG_WORD[31:8]);
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
    import spi_boot_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_en,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    output logic                 wr_en,
    output logic [MEM_SEL_W-1:0] wr_mem,
    output logic [TGT_W-1:0]     wr_addr,
    output logic [7:0]           wr_data,
    output logic                 done,
    output logic                 skipped,
    output logic [TGT_W-1:0]     exec_addr
);
    ldr_state_t st, nx;
    logic [2:0]       idx;
    logic             mode24;
    logic [31:0]      sig_q;
    logic [7:0]       typ_q;
    logic [TGT_W-1:0] rem_q, tgt_q, off_q;
    logic             xstart, xbusy, xdone, xfer_st, is16, is24, idx_clr;
    logic [7:0]       xtx, xrx;
    logic [2:0]       last_addr_idx;

    spi_byte_xfer #(.HALF_DIV(HALF_DIV)) u_xfer (
        .clk(clk), .rst_n(rst_n), .start(xstart), .tx_byte(xtx), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(xbusy), .xdone(xdone), .rx_byte(xrx)
    );

    boot_sig_match u_sig (.sig(sig_q), .is16(is16), .is24(is24));

    assign last_addr_idx = mode24 ? 3'd3 : 3'd2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_STRAP;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            ST_STRAP:   nx = boot_en ? ST_SIG_CMD : ST_SKIP;
            ST_SIG_CMD: if (xdone && idx == 3'd2) nx = ST_SIG_RD;
            ST_SIG_RD:  if (xdone && idx == 3'd3) nx = ST_SIG_CHK;
            ST_SIG_CHK: nx = (is16 || is24) ? ST_REC_CMD : ST_SKIP;
            ST_REC_CMD: if (xdone && idx == last_addr_idx) nx = ST_HDR;
            ST_HDR: if (xdone && idx == 3'd4) begin
                if (typ_q == TYPE_EXEC) nx = ST_EXEC;
                else if (rem_q == '0)   nx = ST_HDR;
                else                    nx = ST_DATA;
            end
            ST_DATA:    if (xdone && rem_q == TGT_W'(1)) nx = ST_HDR;
            ST_EXEC:    nx = ST_EXEC;
            ST_SKIP:    nx = ST_SKIP;
            default:    nx = ST_SKIP;
        endcase
    end

    assign idx_clr = (nx != st) || (st == ST_HDR && xdone && idx == 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0; mode24 <= 1'b0; sig_q <= '0; typ_q <= '0;
            rem_q <= '0; tgt_q <= '0; off_q <= '0; exec_addr <= '0;
            wr_en <= 1'b0; wr_mem <= '0; wr_addr <= '0; wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (idx_clr)    idx <= '0;
            else if (xdone) idx <= idx + 3'd1;
            if (st == ST_SIG_CHK) mode24 <= is24 && !is16;
            if (xdone) begin
                unique case (st)
                    ST_SIG_RD: sig_q <= {sig_q[23:0], xrx};
                    ST_HDR: begin
                        unique case (idx)
                            3'd0: typ_q <= xrx;
                            3'd1: rem_q[7:0] <= xrx;
                            3'd2: rem_q[15:8] <= xrx;
                            3'd3: tgt_q[7:0] <= xrx;
                            default: begin
                                tgt_q[15:8] <= xrx;
                                off_q <= '0;
                                if (typ_q == TYPE_EXEC) exec_addr <= {xrx, tgt_q[7:0]};
                            end
                        endcase
                    end
                    ST_DATA: begin
                        rem_q   <= rem_q - TGT_W'(1);
                        off_q   <= off_q + TGT_W'(1);
                        wr_en   <= (typ_q <= TYPE_LAST_MEM);
                        wr_mem  <= typ_q[MEM_SEL_W-1:0];
                        wr_addr <= tgt_q + off_q;
                        wr_data <= xrx;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        xfer_st = (st == ST_SIG_CMD) || (st == ST_SIG_RD) || (st == ST_REC_CMD)
               || (st == ST_HDR) || (st == ST_DATA);
        cs_n    = !xfer_st;
        xstart  = xfer_st && !xbusy && !xdone;
        done    = (st == ST_EXEC);
        skipped = (st == ST_SKIP);
        xtx     = 8'h00;
        if (st == ST_SIG_CMD && idx == 3'd0) xtx = CMD_READ;
        if (st == ST_REC_CMD)
            xtx = (idx == 3'd0) ? CMD_READ : ((idx == last_addr_idx) ? REC_BASE : 8'h00);
    end
endmodule

// File: rtl/spi_boot_checker.sv
module spi_boot_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk,
    input logic        cs_n,
    input logic        mosi,
    input logic        wr_en,
    input logic [1:0]  wr_mem,
    input logic        done,
    input logic        skipped,
    input logic [15:0] exec_addr
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done && skipped)); // R11
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R11
    AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) skipped |=> skipped); // R11
    AST_NO_WR_AT_END: assert property (@(posedge clk) disable iff (!rst_n) (done || skipped) |=> !wr_en); // R11
    AST_BUS_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) (done || skipped) |-> cs_n); // R10
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R2
    AST_MOSI_HELD_HIGH_SCLK: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R2
    AST_WR_MEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (wr_mem != 2'd3)); // R7
    AST_EXEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> $stable(exec_addr)); // R10
endmodule

bind spi_boot_loader spi_boot_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .wr_en(wr_en), .wr_mem(wr_mem), .done(done), .skipped(skipped),
    .exec_addr(exec_addr)
);

// File: tb/tb_spi_boot_loader.sv
module tb_spi_boot_loader;
    typedef struct packed {
        logic        dev24;
        logic        strap;
        logic        badsig;
        logic        edone;
        logic        eskip;
        logic [15:0] eexec;
        logic [7:0]  enwr;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 8'd7},   // R3 two-byte device
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 8'd7},   // R4 three-byte device
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 8'd0},   // R5 bad signature
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 8'd0},   // R5 bad signature, 3-byte
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'd0}    // R1 strap low
    };
    localparam int NW = 7;
    localparam logic [1:0]  EXP_M [NW] = '{2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 2'd1, 2'd1};
    localparam logic [15:0] EXP_A [NW] = '{16'h0100, 16'h0101, 16'h0102, 16'h0200,
                                           16'h0201, 16'hFFFF, 16'h0000};
    localparam logic [7:0]  EXP_D [NW] = '{8'hAA, 8'hBB, 8'hCC, 8'h01, 8'h02, 8'h5A, 8'hA5};

    logic clk = 1'b0, rst_n = 1'b0, boot_en = 1'b0, miso = 1'b0;
    logic sclk, cs_n, mosi, wr_en, done, skipped;
    logic [1:0] wr_mem;
    logic [15:0] wr_addr, exec_addr;
    logic [7:0] wr_data;

    int nchk = 0, nfail = 0, cyc = 0;
    logic dev24 = 1'b0, cs_seen = 1'b0;
    logic [7:0] img [64];
    int nwr = 0;
    logic [1:0]  got_m [16];
    logic [15:0] got_a [16];
    logic [7:0]  got_d [16];
    int bcnt = 0, hdr = 24, base = 0;
    logic [31:0] shin = '0;

    always #2.5 clk = ~clk;

    spi_boot_loader dut (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .miso(miso), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .wr_en(wr_en), .wr_mem(wr_mem), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .skipped(skipped), .exec_addr(exec_addr)
    );

    // EEPROM model, mode 0, two or three address bytes
    always @(negedge cs_n) begin
        bcnt = 0; shin = '0; miso = 1'b0;
        if (rst_n) cs_seen = 1'b1;
    end
    always @(posedge sclk) if (!cs_n) begin
        if (bcnt < hdr) shin = {shin[30:0], mosi};
        bcnt++;
        if (bcnt == hdr) base = dev24 ? int'(shin[23:0]) : int'(shin[15:0]);
    end
    always @(negedge sclk) if (!cs_n && bcnt >= hdr) begin
        int k;
        k = bcnt - hdr;
        miso = img[(base + k / 8) % 64][7 - (k % 8)];
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n && wr_en) begin
            if (nwr < 16) begin
                got_m[nwr] = wr_mem; got_a[nwr] = wr_addr; got_d[nwr] = wr_data;
            end
            nwr++;
        end
        if (cyc > 190000) begin
            nfail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(int a, logic [7:0] b);
        img[a] = b;
    endtask

    task automatic build_img(logic bad);
        for (int i = 0; i < 64; i++) img[i] = 8'hFF;
        put(0, bad ? 8'h00 : 8'h56); put(1, bad ? 8'h11 : 8'h4C);
        put(2, bad ? 8'h22 : 8'h53); put(3, bad ? 8'h33 : 8'h49);
        // type0 len3 @0x0100
        put(4, 8'h00); put(5, 8'h03); put(6, 8'h00); put(7, 8'h00); put(8, 8'h01);
        put(9, 8'hAA); put(10, 8'hBB); put(11, 8'hCC);
        // unknown type 5, len2
        put(12, 8'h05); put(13, 8'h02); put(14, 8'h00); put(15, 8'h00); put(16, 8'h00);
        put(17, 8'h11); put(18, 8'h22);
        // type1 zero length
        put(19, 8'h01); put(20, 8'h00); put(21, 8'h00); put(22, 8'h40); put(23, 8'h00);
        // type2 len2 @0x0200
        put(24, 8'h02); put(25, 8'h02); put(26, 8'h00); put(27, 8'h00); put(28, 8'h02);
        put(29, 8'h01); put(30, 8'h02);
        // type1 len2 @0xFFFF, wraps
        put(31, 8'h01); put(32, 8'h02); put(33, 8'h00); put(34, 8'hFF); put(35, 8'hFF);
        put(36, 8'h5A); put(37, 8'hA5);
        // execute @0x1234
        put(38, 8'h03); put(39, 8'h00); put(40, 8'h00); put(41, 8'h34); put(42, 8'h12);
    endtask

    task automatic start_run(logic d24, logic strap, logic bad);
        dev24 = d24; hdr = d24 ? 32 : 24; boot_en = strap;
        build_img(bad);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        nwr = 0; cs_seen = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin
            start_run(VEC[v].dev24, VEC[v].strap, VEC[v].badsig);
            if (!VEC[v].strap) begin
                repeat (3) @(negedge clk);
                check("R1 skipped within 3 cycles", int'(skipped), 1);
            end
            for (int c = 0; c < 20000 && !(done || skipped); c++) @(negedge clk);
            repeat (2) @(negedge clk);
            check("R10/R5 done", int'(done), int'(VEC[v].edone));
            check("R5/R1 skipped", int'(skipped), int'(VEC[v].eskip));
            check("R10 exec_addr", int'(exec_addr), int'(VEC[v].eexec));
            check("R8/R9 write count", nwr, int'(VEC[v].enwr));
            if (VEC[v].edone) begin
                for (int w = 0; w < NW && w < nwr; w++) begin
                    check("R7 wr_mem", int'(got_m[w]), int'(EXP_M[w]));
                    check("R7 wr_addr", int'(got_a[w]), int'(EXP_A[w]));
                    check("R6 wr_data", int'(got_d[w]), int'(EXP_D[w]));
                end
            end
            if (!VEC[v].strap) check("R1 cs_n never low", int'(cs_seen), 0);
        end

        // R11 reset state, taken mid-run
        start_run(1'b0, 1'b1, 1'b0);
        repeat (200) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset done", int'(done), 0);
        check("R11 reset skipped", int'(skipped), 0);
        check("R11 reset wr_en", int'(wr_en), 0);
        check("R11 reset cs_n", int'(cs_n), 1);
        check("R2 reset sclk", int'(sclk), 0);

        // R10/R11 terminal hold: no traffic after done
        start_run(1'b1, 1'b1, 1'b0);
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        repeat (300) @(negedge clk);
        check("R11 done held", int'(done), 1);
        check("R11 skipped low", int'(skipped), 0);
        check("R11 no writes after done", nwr, NW);
        check("R10 cs_n high after exec", int'(cs_n), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule